// File: doc/BRIEF.md
# Push-Pull Pulse-Width Modulator with Deadtime Steering

This block is a fixed-frequency digital pulse-width modulator for switch-mode power control. A free-running up-counter forms the ramp. Its cycle length comes from a period input. At the start of every ramp cycle the block latches a compare level. That level is the largest of three values: a feedback control word, a deadtime control word, and a built-in minimum deadtime of one twenty-fifth of the period, rounded up. The active pulse covers the part of the cycle in which the ramp has reached that level. A larger control word therefore gives a shorter pulse, and the shortening is linear.

A steering flip-flop toggles at every cycle start. In push-pull mode it routes successive pulses to drive A and drive B in turn, so each drive runs at half the ramp rate and the two are never on together. In single-ended mode the flip-flop holds its state and both drives carry the same pulse in every cycle. An enable input locks the block out. While it is low the drives stay low, the ramp sits at zero and the steering resets, so the first pulse after enabling goes to drive A.

Top module: `pp_pwm_top`

## Requirements
- R1: One ramp cycle lasts L clocks, where L is the period input latched at cycle start, raised to 2 when it is below 2. The ramp count runs from 0 to L-1 and then restarts.
- R2: Within a cycle a drive may be high only in clocks where the ramp count is greater than or equal to the latched level. The on-time per cycle is therefore L minus the level, and it is zero when the level is L or more.
- R3: The latched level is the larger of the feedback word and the deadtime word, unless the floor of R4 is larger still.
- R4: The level is never below ceil(L/25). With both control words at 0 and L=100, the on-time is 96 clocks per cycle. In push-pull mode that gives each drive 96 high clocks in every 200.
- R5: In the first clock of every ramp cycle (count 0), both drives are low.
- R6: In push-pull mode (single_mode=0) successive cycles alternate between drive A and drive B. The first cycle after the enable rises goes to drive A.
- R7: In single-ended mode (single_mode=1) both drives carry the same pulse in every cycle.
- R8: In push-pull mode drive A and drive B are never high in the same clock.
- R9: The control words, the period and the mode are sampled only at cycle start. A change during a cycle has no effect until the next cycle.
- R10: While reset is asserted or en is low, both drives are low and the ramp is held at zero. The first cycle starts on the clock edge at which en is seen high.
- R11: A control word at or above L (for example 255 with an 8-bit word) gives no pulse on either drive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low acts as a lockout |
| period_in | input | CNT_W | Ramp cycle length in clocks |
| fb_lvl | input | CNT_W | Feedback control word |
| dt_lvl | input | CNT_W | Deadtime control word |
| single_mode | input | 1 | 1 = single-ended, 0 = push-pull |
| drv_a | output | 1 | Drive A |
| drv_b | output | 1 | Drive B |

## Verification
The bench builds the block with the default CNT_W=8 and DT_DIV=25. With these values the bench can use a period of 100, where the 96% cap shows up as an exact clock count. It can also use a period of 255, where a full-scale control word of 255 just reaches the end of the ramp, and a period below 2, where the clamp to a two-clock cycle applies. The minimum-deadtime floor takes several different values across these periods (1, 2, 4 and 11). That lets the bench find cases where the floor, the feedback word or the deadtime word is the largest of the three.

// File: rtl/pp_pwm_pkg.sv
// Shared definitions for the push-pull PWM block.
// Assumes nothing beyond IEEE 1800-2017 packages.
package pp_pwm_pkg;

    // Shortest ramp cycle the block will run, in clocks.
    localparam int MIN_LEN = 2;

    // Output steering mode as latched at cycle start.
    typedef enum logic {
        MODE_PUSHPULL = 1'b0,
        MODE_SINGLE   = 1'b1
    } out_mode_e;

endpackage

// File: rtl/pp_pwm_ramp.sv
// Ramp generator: an up-counter that runs from 0 to len_q-1 and
// raises cyc_start on the clock in which a new cycle is to begin.
// Assumes period_in is only meaningful when sampled at cycle start;
// values below MIN_LEN are raised to MIN_LEN.
module pp_pwm_ramp
    import pp_pwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] period_in,
    output logic [CNT_W-1:0] cnt_q,
    output logic             run_q,
    output logic             cyc_start,
    output logic [CNT_W-1:0] len_eff
);

    localparam logic [CNT_W-1:0] LEN_FLOOR = CNT_W'(MIN_LEN);

    logic [CNT_W-1:0] len_q;

    // Clamp the requested period to the shortest legal cycle.
    always_comb begin
        len_eff = (period_in < LEN_FLOOR) ? LEN_FLOOR : period_in;
    end

    // A cycle begins on the first enabled clock or after the last count.
    always_comb begin
        cyc_start = en && (!run_q || (cnt_q == len_q - 1'b1));
    end

    // Ramp counter, run flag and latched cycle length.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            len_q <= LEN_FLOOR;
        end else if (cyc_start) begin
            cnt_q <= '0;
            run_q <= 1'b1;
            len_q <= len_eff;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q < len_q)); // R1

    AST_LOCKOUT_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0) && !run_q); // R10

endmodule

// File: rtl/pp_pwm_level.sv
// Compare-level selector: latches, at each cycle start, the largest
// of the feedback word, the deadtime word and the minimum-deadtime
// floor ceil(len/DT_DIV). The level is held for the whole cycle.
// Assumes len_eff is the clamped length of the cycle being started.
module pp_pwm_level #(
    parameter int CNT_W  = 8,
    parameter int DT_DIV = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cyc_start,
    input  logic             run_q,
    input  logic [CNT_W-1:0] len_eff,
    input  logic [CNT_W-1:0] fb_lvl,
    input  logic [CNT_W-1:0] dt_lvl,
    output logic [CNT_W-1:0] lvl_q
);

    localparam int          SUM_W = CNT_W + 1;
    localparam logic [SUM_W-1:0] DIV_W = SUM_W'(DT_DIV);
    localparam logic [SUM_W-1:0] RND_W = SUM_W'(DT_DIV - 1);

    logic [SUM_W-1:0] len_rnd;
    logic [CNT_W-1:0] floor_lvl;
    logic [CNT_W-1:0] ctrl_max;
    logic [CNT_W-1:0] lvl_next;

    // Minimum deadtime, rounded up from the cycle length.
    always_comb begin
        len_rnd   = {1'b0, len_eff} + RND_W;
        floor_lvl = CNT_W'(len_rnd / DIV_W);
    end

    // The control word asking for less on-time wins.
    always_comb begin
        ctrl_max = (fb_lvl > dt_lvl) ? fb_lvl : dt_lvl;
        lvl_next = (ctrl_max > floor_lvl) ? ctrl_max : floor_lvl;
    end

    // Latch the level once per cycle; blank fully while locked out.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            lvl_q <= '1;
        end else if (cyc_start) begin
            lvl_q <= lvl_next;
        end
    end

    AST_LVL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !cyc_start && en) |=> $stable(lvl_q)); // R9

    AST_LVL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (lvl_q != '0)); // R4

endmodule

// File: rtl/pp_pwm_steer.sv
// Pulse steering: a flip-flop clocked at each cycle start chooses
// which drive gets the pulse in push-pull mode; in single-ended mode
// the flip-flop holds and both drives follow the pulse. A pulse is
// present while the ramp count has reached the latched level.
// Assumes cnt_q and lvl_q come from the ramp and level stages.
module pp_pwm_steer
    import pp_pwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cyc_start,
    input  logic             single_mode,
    input  logic             run_q,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] lvl_q,
    output logic             drv_a,
    output logic             drv_b
);

    logic      sel_q;
    out_mode_e mode_q;
    logic      pulse;

    // Steering flip-flop and latched mode; reset so A goes first.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sel_q  <= 1'b1;
            mode_q <= MODE_PUSHPULL;
        end else if (cyc_start) begin
            mode_q <= single_mode ? MODE_SINGLE : MODE_PUSHPULL;
            if (!single_mode) begin
                sel_q <= ~sel_q;
            end
        end
    end

    // Modulated pulse: on once the ramp reaches the level.
    always_comb begin
        pulse = run_q && (cnt_q >= lvl_q);
    end

    // Gate the pulse onto the drives according to mode and steering.
    always_comb begin
        drv_a = pulse && ((mode_q == MODE_SINGLE) || !sel_q);
        drv_b = pulse && ((mode_q == MODE_SINGLE) ||  sel_q);
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PUSHPULL) |-> !(drv_a && drv_b)); // R8

    AST_BLANK_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) |-> (!drv_a && !drv_b)); // R5

    AST_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && run_q && !single_mode) |=> (sel_q != $past(sel_q))); // R6

    AST_SINGLE_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SINGLE) |-> (drv_a == drv_b)); // R7

    AST_LOCKOUT_DRV: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!drv_a && !drv_b)); // R10

endmodule

// File: rtl/pp_pwm_top.sv
// Push-pull PWM top level: ramp, level selection and steering.
// Assumes a single clock domain; all inputs are synchronous.
module pp_pwm_top #(
    parameter int CNT_W  = 8,
    parameter int DT_DIV = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] period_in,
    input  logic [CNT_W-1:0] fb_lvl,
    input  logic [CNT_W-1:0] dt_lvl,
    input  logic             single_mode,
    output logic             drv_a,
    output logic             drv_b
);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             cyc_start;
    logic [CNT_W-1:0] len_eff;
    logic [CNT_W-1:0] lvl_q;

    pp_pwm_ramp #(.CNT_W(CNT_W)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .period_in (period_in),
        .cnt_q     (cnt_q),
        .run_q     (run_q),
        .cyc_start (cyc_start),
        .len_eff   (len_eff)
    );

    pp_pwm_level #(.CNT_W(CNT_W), .DT_DIV(DT_DIV)) u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .cyc_start (cyc_start),
        .run_q     (run_q),
        .len_eff   (len_eff),
        .fb_lvl    (fb_lvl),
        .dt_lvl    (dt_lvl),
        .lvl_q     (lvl_q)
    );

    pp_pwm_steer #(.CNT_W(CNT_W)) u_steer (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .cyc_start   (cyc_start),
        .single_mode (single_mode),
        .run_q       (run_q),
        .cnt_q       (cnt_q),
        .lvl_q       (lvl_q),
        .drv_a       (drv_a),
        .drv_b       (drv_b)
    );

endmodule

// File: tb/sim_pp_pwm_top.sv
`timescale 1ns/1ps
module sim_pp_pwm_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] period_in = 8'd100;
    logic [7:0] fb_lvl = 8'd0;
    logic [7:0] dt_lvl = 8'd0;
    logic       single_mode = 1'b0;
    logic       drv_a;
    logic       drv_b;

    int n_chk = 0;
    int n_bad = 0;
    int tot_a = 0;
    int tot_b = 0;
    logic       mon_pp = 1'b0;
    logic [1:0] q_ab[$];
    string      q_tag[$];

    always #2.5 clk = ~clk;

    pp_pwm_top u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .period_in(period_in),
        .fb_lvl(fb_lvl), .dt_lvl(dt_lvl), .single_mode(single_mode),
        .drv_a(drv_a), .drv_b(drv_b)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: pop one expected drive pair per clock and compare.
    always @(negedge clk) begin
        if (q_ab.size() > 0) begin
            logic [1:0] e;
            string t;
            e = q_ab.pop_front();
            t = q_tag.pop_front();
            check(t, {drv_a, drv_b}, e);
            if (mon_pp) check("R8 overlap", drv_a & drv_b, 0);
            tot_a += drv_a;
            tot_b += drv_b;
        end
    end

    // Driver: enable, push expected pairs for ncyc cycles, then lock out.
    task automatic run_seg(input string tag, input int per, input int fb,
                           input int dt, input bit single, input int ncyc,
                           input int exp_a, input int exp_b, input bit midchg);
        int len, flr, lvl;
        len = (per < 2) ? 2 : per;
        flr = (len + 24) / 25;
        lvl = (fb > dt) ? fb : dt;
        if (flr > lvl) lvl = flr;
        @(negedge clk);
        period_in = 8'(per); fb_lvl = 8'(fb); dt_lvl = 8'(dt);
        single_mode = single; en = 1'b1;
        @(posedge clk);
        #1;
        tot_a = 0; tot_b = 0; mon_pp = !single;
        for (int c = 0; c < ncyc; c++) begin
            for (int k = 0; k < len; k++) begin
                bit on, ea, eb;
                on = (k >= lvl);
                ea = on && (single || (c % 2 == 0));
                eb = on && (single || (c % 2 == 1));
                q_ab.push_back({ea, eb});
                q_tag.push_back(tag);
            end
        end
        if (midchg) begin
            repeat (len / 2) @(posedge clk);
            #1;
            fb_lvl = 8'd255; dt_lvl = 8'd0; period_in = 8'd7; single_mode = 1'b1;
        end
        while (q_ab.size() != 0) @(posedge clk);
        #1;
        en = 1'b0;
        mon_pp = 1'b0;
        check({tag, " total A"}, tot_a, exp_a);
        check({tag, " total B"}, tot_b, exp_b);
        // Lockout: inputs that would pulse must have no effect.
        @(posedge clk);
        #1;
        fb_lvl = 8'd0; dt_lvl = 8'd0; single_mode = 1'b1; period_in = 8'd4;
        repeat (6) begin
            @(negedge clk);
            check("R10 lockout", {drv_a, drv_b}, 0);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        en = 1'b1; fb_lvl = 8'd0;
        repeat (4) @(negedge clk);
        check("R10 reset drive A", drv_a, 0);
        check("R10 reset drive B", drv_b, 0);
        en = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 idle", {drv_a, drv_b}, 0);

        run_seg("R4 R6 push-pull cap", 100, 0, 0, 1'b0, 4, 192, 192, 1'b0);
        run_seg("R4 R7 single cap", 100, 0, 0, 1'b1, 2, 192, 192, 1'b0);
        run_seg("R3 feedback wins", 20, 12, 5, 1'b0, 4, 16, 16, 1'b0);
        run_seg("R3 deadtime wins", 20, 3, 15, 1'b0, 4, 10, 10, 1'b0);
        run_seg("R4 floor wins", 50, 1, 0, 1'b1, 2, 96, 96, 1'b0);
        run_seg("R11 full scale", 100, 255, 0, 1'b0, 2, 0, 0, 1'b0);
        run_seg("R11 full scale long", 255, 0, 255, 1'b1, 1, 0, 0, 1'b0);
        run_seg("R2 last count", 30, 29, 0, 1'b0, 2, 1, 1, 1'b0);
        run_seg("R1 short period", 1, 0, 0, 1'b1, 3, 3, 3, 1'b0);
        run_seg("R9 mid-cycle change", 40, 10, 0, 1'b0, 1, 30, 0, 1'b1);
        run_seg("R5 R6 restart A first", 10, 0, 6, 1'b0, 3, 8, 4, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule